// File: doc/BRIEF.md
# Pin Interrupt Controller with Conditional Acknowledge

This block watches a group of general-purpose input pins and folds activity on them into one interrupt request. Software chooses which pins take part, whether each pin is active low or active high, and whether the controller reacts to active edges only or also to a pin that simply sits at its active level. Any qualifying event on a participating pin sets one shared flag; the request line is that flag gated by an interrupt enable.

The flag is cleared by writing an acknowledge bit, but the clear is conditional: it takes effect only when every participating pin is back at its inactive level. A pin still held active keeps the flag set, so an event cannot be lost by acknowledging too early. Because enabling a pin can produce a spurious flag, software is expected to configure the pins with the interrupt enable off, acknowledge, and only then turn the enable on. The block also drives per-pin pull-resistor controls: a pull is engaged only when its pull-enable bit is set, and its direction follows the pin's polarity bit (pull-up for active-low pins, pull-down for active-high pins).

Pin inputs are asynchronous and pass through a two-flop synchronizer. All configuration is reached through a single-cycle synchronous register write port and a combinational read port.

Top module: `pint_ctrl`

## Requirements
- R1: After reset the selection, polarity, pull-enable, interrupt-enable, mode and flag state are all 0, so `irq`, `pull_up` and `pull_dn` are all 0 and every register reads as 0.
- R2: In either mode, an active edge on a selected pin sets the flag; polarity bit 0 makes a falling edge active, polarity bit 1 a rising edge. The opposite edge does not set the flag.
- R3: `irq` is 1 exactly when the flag and the interrupt-enable bit are both 1; the enable does not alter the flag.
- R4: A write of 1 to the acknowledge bit clears the flag on that clock edge when every selected pin is at its inactive level.
- R5: A write of 1 to the acknowledge bit leaves the flag set when any selected pin is at its active level.
- R6: A pin whose select bit is 0 never sets the flag and is ignored when an acknowledge is judged.
- R7: For each pin, `pull_up` = pull-enable AND NOT polarity, and `pull_dn` = pull-enable AND polarity.
- R8: With mode bit 0 a selected pin already held at its active level does not set the flag; with mode bit 1 it sets the flag on every cycle, so acknowledge cannot clear it until the pin goes inactive.
- R9: The acknowledge bit always reads back 0, and writing 0 to it leaves the flag unchanged.
- R10: Register map, address on `bus_addr`: 0 = control (bit 0 flag, read-only; bit 1 acknowledge, write-only; bit 2 interrupt enable; bit 3 mode), 1 = pin select, 2 = polarity, 3 = pull enable; bit n of registers 1 to 3 belongs to pin n. Writes take effect on the clock edge where `bus_wr` is 1, and reads of registers 1 to 3 return the last value written.
- R11: A pin change that is stable before a rising clock edge shows in the flag after the third rising edge counted from that one, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NPINS | Asynchronous pin levels |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| pull_up | output | NPINS | Per-pin pull-up engage |
| pull_dn | output | NPINS | Per-pin pull-down engage |

## Verification
The assertions place no constraint on the pin inputs, which may change at any time; they take for granted that `bus_wr` is a one-cycle strobe and that an acknowledge is recognised only on a control-register write, so they relate the flag to the detector's qualified events and the acknowledge strobe rather than to raw pin values. The stimulus changes pins and bus signals only at falling clock edges and holds each pin level for at least four cycles before observing the flag, so every expected value is settled through the synchronizer; only the latency check samples earlier, on purpose.

// File: rtl/pint_pkg.sv
// Shared register addresses and control-register bit positions for the
// pin interrupt controller. Assumes a data word of at least four bits.
package pint_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_SEL  = 2'd1;
    localparam logic [ADDR_W-1:0] A_POL  = 2'd2;
    localparam logic [ADDR_W-1:0] A_PULL = 2'd3;

    localparam int B_FLAG = 0;
    localparam int B_ACK  = 1;
    localparam int B_IE   = 2;
    localparam int B_MODE = 3;
endpackage

// File: rtl/pint_sync.sv
// Two-stage synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is sampled independently; no bus coherence is implied.
module pint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Two flops in series to settle metastable samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/pint_detect.sv
// Per-pin active-edge and active-level detection.
// Assumes s_in is already synchronized. The previous sample is judged with
// the current polarity, so a polarity change alone never creates an edge.
module pint_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] sel,
    input  logic         level_mode,
    output logic         hit_any,
    output logic         asserted_any
);
    logic [W-1:0] s_prev;
    logic [W-1:0] hit;
    logic [W-1:0] asserted;

    // Keep last cycle's synchronized value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) s_prev <= '0;
        else        s_prev <= s_in;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic act_now;
        logic act_before;
        // Map each pin to "active" according to its polarity and qualify it.
        always_comb begin
            act_now     = ~(s_in[i]   ^ pol[i]);
            act_before  = ~(s_prev[i] ^ pol[i]);
            asserted[i] = sel[i] & act_now;
            hit[i]      = sel[i] & ((act_now & ~act_before) | (level_mode & act_now));
        end
    end

    // Reduce per-pin results to the shared controller signals.
    always_comb begin
        hit_any      = |hit;
        asserted_any = |asserted;
    end
endmodule

// File: rtl/pint_regs.sv
// Configuration registers, shared interrupt flag and read mux.
// Assumes bus_wr is a single-cycle strobe. A detected event has priority
// over a clearing acknowledge in the same cycle.
module pint_regs
    import pint_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              hit_any,
    input  logic              asserted_any,
    output logic [W-1:0]      sel,
    output logic [W-1:0]      pol,
    output logic [W-1:0]      pull_en,
    output logic              ie,
    output logic              level_mode,
    output logic              flag,
    output logic              ack_wr
);
    logic ctrl_wr;

    // Decode control writes and the acknowledge strobe.
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == A_CTRL);
        ack_wr  = ctrl_wr && bus_wdata[B_ACK];
    end

    // Configuration register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel        <= '0;
            pol        <= '0;
            pull_en    <= '0;
            ie         <= 1'b0;
            level_mode <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    ie         <= bus_wdata[B_IE];
                    level_mode <= bus_wdata[B_MODE];
                end
                A_SEL:   sel     <= bus_wdata;
                A_POL:   pol     <= bus_wdata;
                default: pull_en <= bus_wdata;
            endcase
        end
    end

    // Shared flag: set by any event, cleared only by a permitted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                         flag <= 1'b0;
        else if (hit_any)                   flag <= 1'b1;
        else if (ack_wr && !asserted_any)   flag <= 1'b0;
    end

    // Read mux; the acknowledge bit is write-only and reads as zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_FLAG] = flag;
                bus_rdata[B_IE]   = ie;
                bus_rdata[B_MODE] = level_mode;
            end
            A_SEL:   bus_rdata = sel;
            A_POL:   bus_rdata = pol;
            default: bus_rdata = pull_en;
        endcase
    end
endmodule

// File: rtl/pint_ctrl.sv
// Top level of the pin interrupt controller: synchronizer, detector,
// register file, request gating and pull-control outputs.
// Assumes NPINS >= 4 so the control bits fit in one data word.
module pint_ctrl
    import pint_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    output logic              irq,
    output logic [NPINS-1:0]  pull_up,
    output logic [NPINS-1:0]  pull_dn
);
    localparam int W = NPINS;

    logic [W-1:0] pin_s;
    logic [W-1:0] sel;
    logic [W-1:0] pol;
    logic [W-1:0] pull_en;
    logic         ie;
    logic         level_mode;
    logic         flag;
    logic         ack_wr;
    logic         hit_any;
    logic         asserted_any;

    pint_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_s)
    );

    pint_detect #(.W(W)) u_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_in         (pin_s),
        .pol          (pol),
        .sel          (sel),
        .level_mode   (level_mode),
        .hit_any      (hit_any),
        .asserted_any (asserted_any)
    );

    pint_regs #(.W(W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .hit_any      (hit_any),
        .asserted_any (asserted_any),
        .sel          (sel),
        .pol          (pol),
        .pull_en      (pull_en),
        .ie           (ie),
        .level_mode   (level_mode),
        .flag         (flag),
        .ack_wr       (ack_wr)
    );

    // Gate the request with the interrupt enable.
    always_comb irq = flag & ie;

    for (genvar i = 0; i < W; i++) begin : g_pull
        // Pull engages only when enabled; polarity picks its direction.
        always_comb begin
            pull_up[i] = pull_en[i] & ~pol[i];
            pull_dn[i] = pull_en[i] &  pol[i];
        end
    end
endmodule

// File: rtl/pint_ctrl_chk.sv
// Property checker for pint_ctrl, attached by bind. Relates the flag to
// qualified detector events and to the acknowledge strobe.
module pint_ctrl_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq,
    input logic         flag,
    input logic         ie,
    input logic         ack_wr,
    input logic         hit_any,
    input logic         asserted_any,
    input logic [W-1:0] pull_up,
    input logic [W-1:0] pull_dn
);
    // R2: a qualified event always leaves the flag set.
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> flag);

    // R6: the flag only rises after a qualified event on a selected pin.
    a_r6_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit_any));

    // R4: a permitted acknowledge with no concurrent event clears the flag.
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !asserted_any && !hit_any) |=> !flag);

    // R5: an acknowledge while a selected pin is active keeps the flag.
    a_r5_ack_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ack_wr && asserted_any) |=> flag);

    // R9: the flag falls only as the result of an acknowledge write.
    a_r9_fall_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(ack_wr));

    // R3: no request without both the flag and the enable.
    a_r3_irq_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && ie));

    // R7: a pin never has both pull directions engaged.
    a_r7_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up & pull_dn) == '0);
endmodule

bind pint_ctrl pint_ctrl_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq          (irq),
    .flag         (flag),
    .ie           (ie),
    .ack_wr       (ack_wr),
    .hit_any      (hit_any),
    .asserted_any (asserted_any),
    .pull_up      (pull_up),
    .pull_dn      (pull_dn)
);

// File: tb/test_pint_ctrl.sv
`timescale 1ns/1ps
module test_pint_ctrl;
    localparam int W = 8;
    localparam logic [1:0] A_CTRL = 2'd0, A_SEL = 2'd1, A_POL = 2'd2, A_PULL = 2'd3;
    localparam logic [W-1:0] ACK = 8'h02, IE = 8'h04, MODE = 8'h08;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_in = '1;
    logic [1:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;
    logic [W-1:0] pull_up;
    logic [W-1:0] pull_dn;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    pint_ctrl #(.NPINS(W)) i_pint_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .pull_up(pull_up), .pull_dn(pull_dn)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic flag_is(input string req, input logic exp);
        logic [W-1:0] v;
        rd(A_CTRL, v);
        check(req, {7'b0, v[0]}, {7'b0, exp});
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] idle;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 pull_up", pull_up, 8'h00);
        check("R1 pull_dn", pull_dn, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 register", v, 8'h00);
        end

        // R10: readback of configuration registers
        wr(A_SEL, 8'hA5); wr(A_POL, 8'h3C); wr(A_PULL, 8'h0F);
        rd(A_SEL, v);  check("R10 sel", v, 8'hA5);
        rd(A_POL, v);  check("R10 pol", v, 8'h3C);
        rd(A_PULL, v); check("R10 pull", v, 8'h0F);
        wr(A_SEL, 8'h00); wr(A_POL, 8'h00); wr(A_PULL, 8'h00);

        // R7: pull control sweep
        for (int pe = 0; pe < 16; pe++) begin
            for (int es = 0; es < 16; es++) begin
                logic [W-1:0] pev, esv;
                pev = {4'(pe), 4'(pe)};
                esv = {4'(es), ~4'(es)};
                wr(A_PULL, pev); wr(A_POL, esv);
                check("R7 pull_up", pull_up, pev & ~esv);
                check("R7 pull_dn", pull_dn, pev & esv);
            end
        end
        wr(A_PULL, 8'h00);

        // R2 R4 R5 R6 R8: sweep every pin under both polarities, edge mode
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < W; i++) begin
                int j;
                logic [W-1:0] bi, bj;
                j = (i + 1) % W;
                bi = 8'(1) << i;
                bj = 8'(1) << j;
                idle = (p == 1) ? 8'h00 : 8'hFF;
                pin_in = idle;
                wr(A_CTRL, 8'h00); wr(A_SEL, 8'h00);
                wr(A_POL, (p == 1) ? 8'hFF : 8'h00);
                wait_cyc(4);
                // R8: pin already active before selection, edge mode: no flag
                pin_in = idle ^ bi; wait_cyc(4);
                wr(A_SEL, bi); wait_cyc(4);
                flag_is("R8 held level ignored in edge mode", 1'b0);
                // R2: opposite edge does not set
                pin_in = idle; wait_cyc(4);
                flag_is("R2 opposite edge", 1'b0);
                // R6: disabled pin goes active
                pin_in = idle ^ bj; wait_cyc(4);
                flag_is("R6 disabled pin", 1'b0);
                // R2: active edge sets
                pin_in = idle ^ bj ^ bi; wait_cyc(4);
                flag_is("R2 active edge", 1'b1);
                // R5: acknowledge while active
                wr(A_CTRL, ACK);
                flag_is("R5 ack blocked", 1'b1);
                // R4 R6: pin inactive, disabled pin still active, ack clears
                pin_in = idle ^ bj; wait_cyc(4);
                flag_is("R2 flag held", 1'b1);
                wr(A_CTRL, ACK);
                flag_is("R4 ack clears", 1'b0);
                pin_in = idle; wait_cyc(4);
                flag_is("R6 disabled release", 1'b0);
            end
        end

        // R11: latency
        pin_in = 8'hFF; wr(A_POL, 8'h00); wr(A_SEL, 8'h01); wr(A_CTRL, 8'h00);
        wait_cyc(4); wr(A_CTRL, ACK);
        pin_in = 8'hFE;
        wait_cyc(2);
        flag_is("R11 not after two edges", 1'b0);
        wait_cyc(1);
        flag_is("R11 set after three edges", 1'b1);

        // R3: request gating
        check("R3 irq off with ie 0", {7'b0, irq}, 8'h00);
        wr(A_CTRL, IE);
        check("R3 irq on", {7'b0, irq}, 8'h01);
        // R9: acknowledge reads back 0, writing 0 leaves the flag
        rd(A_CTRL, v);
        check("R9 ctrl readback", v, 8'h05);
        wr(A_CTRL, 8'h00);
        check("R3 irq off", {7'b0, irq}, 8'h00);
        flag_is("R9 ack zero no effect", 1'b1);
        wr(A_CTRL, ACK | IE);
        rd(A_CTRL, v);
        check("R9 ack reads zero", v, 8'h05);
        pin_in = 8'hFF; wait_cyc(4);
        wr(A_CTRL, ACK | IE);
        check("R3 irq after clear", {7'b0, irq}, 8'h00);

        // R8: level mode
        wr(A_SEL, 8'h00); wr(A_CTRL, MODE);
        pin_in = 8'hFE; wait_cyc(4);
        flag_is("R8 unselected level", 1'b0);
        wr(A_SEL, 8'h01); wait_cyc(1);
        flag_is("R8 level sets", 1'b1);
        wr(A_CTRL, MODE | ACK);
        flag_is("R8 level ack blocked", 1'b1);
        pin_in = 8'hFF; wait_cyc(4);
        wr(A_CTRL, MODE | ACK);
        flag_is("R8 level ack clears", 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule